// File: doc/BRIEF.md
# Streaming Sine-Cosine Generator

This block turns a stream of phase angles into a stream of sine and cosine pairs. Each cycle it may take one signed fixed-point phase. It returns, a fixed number of cycles later, one word that carries the cosine in its low half and the sine in its high half. Inside is a fully pipelined circular CORDIC in rotation mode, built from shift-and-add micro-rotations. It uses no multiplier.

A fold stage at the front lets the block cover the whole circle. A phase beyond plus or minus a quarter turn is moved by half a turn, which brings it into the range where the micro-rotations converge. The cosine and sine that come out are then negated to undo the move. The X register starts at the reciprocal of the rotation gain and Y starts at zero, so the outputs need no scaling afterwards. The result is rounded to the output format and clamped at the largest positive code, so it never wraps.

The block suits waveform generation behind a phase source, or any datapath that needs both trigonometric values of one angle. It accepts a new phase every cycle and never stalls. Results leave in the order the phases arrived.

Top module: `sincos_stream`

## Requirements
- R1: While reset is high, `m_sc_valid` is low. After reset it stays low until the first accepted phase has had time to reach the output.
- R2: The phase input is a 16-bit two's-complement value, taken as the code divided by 8192 radians. The output word holds the cosine in bits 15:0 and the sine in bits 31:16. Each half is a 16-bit two's-complement value taken as the code divided by 32768. For phases with magnitude up to pi/2, each half is within 6 codes of the rounded ideal value.
- R3: For phases whose magnitude lies between pi/2 and pi, both halves are also within 6 codes of the rounded ideal value. This includes the codes on either side of the pi/2 fold point (12867 and 12868, and their negatives).
- R4: A result whose ideal rounded value would be +32768 is returned as 32767 and never wraps to a negative code. Examples are the cosine at phase 0 and the sine at pi/2.
- R5: Every output appears exactly N_STAGES + 2 clock cycles after the cycle in which its phase was accepted. That is 18 cycles with the default 16 stages.
- R6: Phases may arrive on consecutive cycles. Each accepted phase gives exactly one valid output, and the outputs come in input order.
- R7: In a cycle with `s_phase_valid` low, nothing is accepted. No output is produced for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_phase_valid | input | 1 | Phase word is present this cycle |
| s_phase_data | input | 16 | Signed phase, 13 fractional bits |
| m_sc_valid | output | 1 | Result word is present this cycle |
| m_sc_data | output | 32 | Sine in bits 31:16, cosine in bits 15:0, each with 15 fractional bits |

## Verification
The assertions take it for granted that `s_phase_valid` is low while reset is asserted. They also assume every phase code lies within plus or minus 25736. Those inputs keep the folded angle inside the convergence zone. They also keep the vector magnitude in every stage below 1.25 and the residual angle after the last stage near zero. The stimulus leaves the valid input low throughout reset. It draws every phase, both the directed points and the sweep, from the range -25735 to +25735. Beyond the sweep, it targets the fold thresholds, the two saturating points and spacing with idle gaps.

// File: rtl/sc_pkg.sv
package sc_pkg;

    // phase input format
    localparam int PH_W    = 16;
    localparam int PH_FRAC = 13;
    // output component format
    localparam int OUT_W   = 16;
    localparam int GUARD   = 2;
    // internal datapath
    localparam int FRAC    = OUT_W - 1 + GUARD;         // 17
    localparam int IW      = FRAC + 3;                  // 20
    localparam int ZW      = PH_W + (FRAC - PH_FRAC);   // 20
    localparam int PAD     = ZW - PH_W;
    localparam int MAX_STAGES = 18;

    // constants in the internal formats (FRAC = 17)
    localparam logic signed [ZW-1:0] PI_Z      = 20'sd411775;
    localparam logic signed [ZW-1:0] HALF_PI_Z = 20'sd205887;
    localparam logic signed [IW-1:0] INV_GAIN  = 20'sd79594;
    localparam logic signed [IW-1:0] MAG_LIM   = 20'sd163840;
    localparam logic signed [ZW-1:0] RESID_LIM = 20'sd64;
    localparam logic signed [IW-1:0] RND       = IW'(1) << (GUARD - 1);
    localparam logic signed [IW-1:0] OUT_HI    = IW'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [IW-1:0] OUT_LO    = -IW'(1 << (OUT_W - 1));

    typedef struct packed {
        logic                 valid;
        logic                 flip;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [ZW-1:0] z;
    } rot_t;

    // arctangent of 2^-i, radians scaled by 2^FRAC
    function automatic logic signed [ZW-1:0] atan_step(input int i);
        case (i)
            0:  return 20'sd102944;
            1:  return 20'sd60771;
            2:  return 20'sd32110;
            3:  return 20'sd16299;
            4:  return 20'sd8181;
            5:  return 20'sd4095;
            6:  return 20'sd2048;
            7:  return 20'sd1024;
            8:  return 20'sd512;
            9:  return 20'sd256;
            10: return 20'sd128;
            11: return 20'sd64;
            12: return 20'sd32;
            13: return 20'sd16;
            14: return 20'sd8;
            15: return 20'sd4;
            16: return 20'sd2;
            17: return 20'sd1;
            default: return '0;
        endcase
    endfunction

    // round away the guard bits, clamp into the output range
    function automatic logic signed [OUT_W-1:0] sat_round(input logic signed [IW-1:0] v);
        logic signed [IW-1:0] r;
        r = (v + RND) >>> GUARD;
        if (r > OUT_HI)      return OUT_W'(OUT_HI);
        else if (r < OUT_LO) return OUT_W'(OUT_LO);
        else                 return OUT_W'(r);
    endfunction

endpackage

// File: rtl/sc_fold.sv
module sc_fold
    import sc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [PH_W-1:0] in_phase,
    output rot_t            dout
);

    logic signed [ZW-1:0] p;
    logic signed [ZW-1:0] z_n;
    logic                 flip_n;

    always_comb begin
        p = {in_phase, {PAD{1'b0}}};
        if (p > HALF_PI_Z) begin
            z_n    = p - PI_Z;
            flip_n = 1'b1;
        end else if (p < -HALF_PI_Z) begin
            z_n    = p + PI_Z;
            flip_n = 1'b1;
        end else begin
            z_n    = p;
            flip_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            dout.valid <= in_valid;
            dout.flip  <= flip_n;
            dout.x     <= INV_GAIN;
            dout.y     <= '0;
            dout.z     <= z_n;
        end
    end

    AST_FOLD_VALID: assert property (@(posedge clk) disable iff (rst)
        dout.valid == $past(in_valid)) else $error("fold valid"); // R7

    AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (rst)
        dout.valid |-> (dout.z <= HALF_PI_Z && dout.z >= -HALF_PI_Z)) else $error("fold range"); // R3

endmodule

// File: rtl/sc_rotate_stage.sv
module sc_rotate_stage
    import sc_pkg::*;
#(
    parameter int                   SHIFT     = 0,
    parameter logic signed [ZW-1:0] ATAN_STEP = '0
)(
    input  logic clk,
    input  logic rst,
    input  rot_t din,
    output rot_t dout
);

    logic signed [IW-1:0] xi, yi, xs, ys, xo, yo;
    logic signed [ZW-1:0] zi;

    always_comb begin
        xi = din.x;
        yi = din.y;
        zi = din.z;
        xs = xi >>> SHIFT;
        ys = yi >>> SHIFT;
        xo = dout.x;
        yo = dout.y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            dout.valid <= din.valid;
            dout.flip  <= din.flip;
            if (zi[ZW-1]) begin
                dout.x <= xi + ys;
                dout.y <= yi - xs;
                dout.z <= zi + ATAN_STEP;
            end else begin
                dout.x <= xi - ys;
                dout.y <= yi + xs;
                dout.z <= zi - ATAN_STEP;
            end
        end
    end

    AST_STAGE_VALID: assert property (@(posedge clk) disable iff (rst)
        dout.valid == $past(din.valid)) else $error("stage valid"); // R6

    AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (rst)
        dout.valid |-> (xo < MAG_LIM && xo > -MAG_LIM && yo < MAG_LIM && yo > -MAG_LIM))
        else $error("stage magnitude"); // R2

endmodule

// File: rtl/sc_pack.sv
module sc_pack
    import sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rot_t              din,
    output logic              out_valid,
    output logic [2*OUT_W-1:0] out_data
);

    logic signed [IW-1:0]    cx, sy;
    logic signed [ZW-1:0]    resid;
    logic signed [OUT_W-1:0] cos_q, sin_q;

    always_comb begin
        cx    = din.flip ? -din.x : din.x;
        sy    = din.flip ? -din.y : din.y;
        resid = din.z;
        cos_q = sat_round(cx);
        sin_q = sat_round(sy);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= din.valid;
            out_data  <= {sin_q, cos_q};
        end
    end

    AST_PACK_VALID: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(din.valid)) else $error("pack valid"); // R5

    AST_RESIDUAL: assert property (@(posedge clk) disable iff (rst)
        din.valid |-> (resid < RESID_LIM && resid > -RESID_LIM)) else $error("residual angle"); // R2

endmodule

// File: rtl/sincos_stream.sv
module sincos_stream
    import sc_pkg::*;
#(
    parameter int N_STAGES = 16
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        s_phase_valid,
    input  logic [15:0] s_phase_data,
    output logic        m_sc_valid,
    output logic [31:0] m_sc_data
);

    localparam int LATENCY = N_STAGES + 2;

    rot_t chain [0:N_STAGES];

    sc_fold u_fold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (s_phase_valid),
        .in_phase (s_phase_data),
        .dout     (chain[0])
    );

    for (genvar g = 0; g < N_STAGES; g++) begin : g_rot
        sc_rotate_stage #(
            .SHIFT     (g),
            .ATAN_STEP (atan_step(g))
        ) u_stage (
            .clk  (clk),
            .rst  (rst),
            .din  (chain[g]),
            .dout (chain[g+1])
        );
    end

    sc_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .din       (chain[N_STAGES]),
        .out_valid (m_sc_valid),
        .out_data  (m_sc_data)
    );

    // R5: LATENCY cycles from acceptance to output
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !m_sc_valid) else $error("valid during reset"); // R1

endmodule

// File: tb/sincos_stream_test.sv
module sincos_stream_test;

    localparam int N_STAGES = 16;
    localparam int LAT      = N_STAGES + 2;
    localparam int TOL      = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_phase_valid = 1'b0;
    logic [15:0] s_phase_data = '0;
    logic        m_sc_valid;
    logic [31:0] m_sc_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int sent = 0;
    int got = 0;
    bit done = 1'b0;

    int    q_sin[$];
    int    q_cos[$];
    int    q_stamp[$];
    string q_tag[$];

    sincos_stream #(.N_STAGES(N_STAGES)) uut (
        .clk           (clk),
        .rst           (rst),
        .s_phase_valid (s_phase_valid),
        .s_phase_data  (s_phase_data),
        .m_sc_valid    (m_sc_valid),
        .m_sc_data     (m_sc_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int to_q15(input real v);
        real s;
        int  r;
        s = v * 32768.0;
        if (s >= 0.0) r = $rtoi(s + 0.5);
        else          r = -$rtoi(-s + 0.5);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // driver: present one phase for one cycle, queue the expected result
    task automatic send(input int code, input string tag);
        real th;
        @(negedge clk);
        th = real'(code) / 8192.0;
        s_phase_valid = 1'b1;
        s_phase_data  = 16'(code);
        q_sin.push_back(to_q15($sin(th)));
        q_cos.push_back(to_q15($cos(th)));
        q_stamp.push_back(cyc);
        q_tag.push_back(tag);
        sent++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_phase_valid = 1'b0;
            s_phase_data  = 16'h5A5A;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && m_sc_valid) begin
            int as, ac, es, ec, st;
            string tg;
            as = int'($signed(m_sc_data[31:16]));
            ac = int'($signed(m_sc_data[15:0]));
            got++;
            checks++;
            if (q_sin.size() == 0) begin
                failures++;
                $display("FAIL R7 unexpected output: actual valid=1 expected valid=0 (data %h)", m_sc_data);
            end else begin
                es = q_sin.pop_front();
                ec = q_cos.pop_front();
                st = q_stamp.pop_front();
                tg = q_tag.pop_front();
                if (absdiff(as, es) > TOL || absdiff(ac, ec) > TOL) begin
                    failures++;
                    $display("FAIL %s value: actual sin=%0d cos=%0d expected sin=%0d cos=%0d",
                             tg, as, ac, es, ec);
                end
                checks++;
                if (cyc - st != LAT) begin
                    failures++;
                    $display("FAIL R5 latency: actual %0d expected %0d", cyc - st, LAT);
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: quiet during and right after reset
        repeat (4) begin
            @(negedge clk);
            checks++;
            if (m_sc_valid !== 1'b0) begin
                failures++;
                $display("FAIL R1 valid in reset: actual %b expected 0", m_sc_valid);
            end
        end
        rst = 1'b0;
        repeat (LAT + 2) begin
            @(negedge clk);
            checks++;
            if (m_sc_valid !== 1'b0) begin
                failures++;
                $display("FAIL R1 valid after reset: actual %b expected 0", m_sc_valid);
            end
        end

        // R4: saturating points
        send(0, "R4");
        send(12868, "R4");
        idle(3);
        // R2: unfolded range
        send(4000, "R2");
        send(-4000, "R2");
        send(6434, "R2");
        send(-9000, "R2");
        send(12867, "R2");
        send(-12867, "R2");
        idle(2);
        // R3: folded range and thresholds
        send(-12868, "R3");
        send(12869, "R3");
        send(-12869, "R3");
        send(20000, "R3");
        send(-20000, "R3");
        send(25735, "R3");
        send(-25735, "R3");
        idle(LAT + 4);

        // R6: back-to-back sweep over the circle
        for (int c = -25735; c <= 25735; c += 257) send(c, "R6");
        idle(5);

        // R7: sparse traffic with idle gaps
        for (int k = 0; k < 20; k++) begin
            send(k * 2411 - 23000, "R7");
            idle(k % 4 + 1);
        end

        idle(LAT + 4);
        checks++;
        if (got != sent || q_sin.size() != 0) begin
            failures++;
            $display("FAIL R6 output count: actual %0d expected %0d", got, sent);
        end
        done = 1'b1;
        finish_run();
    end

endmodule